// File: doc/BRIEF.md
# Trace Buffer Register Access Chain

This block is the serial side of a trace buffer's register bank. A debugger reaches it through the test-access port. It loads a 40-bit word into the chain, and an update then turns that word into a single write or a single read on the parallel register interface. The state machine and instruction decoding of the test port lie outside the block. They arrive only as a select input and the capture, shift and update strobes. The select is high while scan chain number 0 is chosen and the register-access instruction is loaded.

The chain holds three fields. Bits 0 to 31 carry the data word, bits 32 to 38 carry the register address and bit 39 carries the direction flag. Bit 0 leaves on the serial output first, and the serial input enters at bit 39.

Reads are pipelined across scans. A read update pulses a read strobe for one cycle and keeps the returned word in a shadow register. The next capture loads that word into the data field, so a read's result comes out during the following scan. The trace RAM window at address 4 advances on every read. For this reason, a stream of trace words should end with a scan that reads the harmless identification register at address 0.

Top module: `trace_reg_chain`

## Requirements
- R1: After reset, `tdo`, `regWe`, `regRe`, `regAddr` and `regWdata` are all zero, and the first capture loads an all-zero chain.
- R2: Each shift cycle, taken while selected, moves the chain one place toward bit 0 and places `tdi` in bit 39. `tdo` always shows bit 0.
- R3: A capture loads the shadow word into bits 31:0 and clears the address bits 38:32 and the flag bit 39.
- R4: An update whose flag bit 39 is 1 raises `regWe` for exactly one cycle, in the cycle after the update. During that cycle `regAddr` equals bits 38:32, `regWdata` equals bits 31:0 and `regRe` is 0.
- R5: An update whose flag bit 39 is 0 raises `regRe` for exactly one cycle, in the cycle after the update. During that cycle `regAddr` equals bits 38:32 and `regWe` is 0.
- R6: The `regRdata` value seen during a read strobe is stored in the shadow register. It appears in the data field of the next capture, so each scan returns the result of the previous read.
- R7: A write update, or any cycle without a read strobe, leaves the shadow word unchanged.
- R8: While `chainSel` is 0, the capture, shift and update strobes have no effect. No register strobe is raised and the chain contents are kept.
- R9: `regAddr` and `regWdata` hold the values taken at the last update, while later shifting goes on.
- R10: Each read update gives exactly one read strobe. K scans reading address 4, followed by one scan reading address 0, therefore pull exactly K consecutive trace words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Active-low reset |
| chainSel | input | 1 | High when scan chain 0 and the access instruction are active |
| captureDr | input | 1 | Capture strobe from the test port |
| shiftDr | input | 1 | Shift strobe from the test port |
| updateDr | input | 1 | Update strobe from the test port |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| regAddr | output | 7 | Register address toward the bank |
| regWdata | output | 32 | Write data toward the bank |
| regWe | output | 1 | One-cycle write strobe |
| regRe | output | 1 | One-cycle read strobe |
| regRdata | input | 32 | Read data from the bank, valid while `regRe` is high |

## Verification
The assertions assume that the test port raises at most one of capture, shift and update in any cycle. They also assume that two updates never fall on adjacent cycles, which is the case for any legal walk through the test-port states. The bench drives every scan as one capture pulse, forty single shift cycles and one update pulse, with idle cycles in between. It never overlaps strobes, so the stimulus stays inside those assumptions. The register bank on the bench side returns its read word combinationally during the read strobe. This matches the way the shadow register samples it.

// File: rtl/trace_chain_pkg.sv
package trace_chain_pkg;
  // Qualified strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic loadShadow;
  } chainStrobes_t;
endpackage

// File: rtl/trace_chain_ctrl.sv
module trace_chain_ctrl
  import trace_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          chainSel,
  input  logic          captureDr,
  input  logic          shiftDr,
  input  logic          updateDr,
  input  logic          flagBit,
  output chainStrobes_t stb,
  output logic          regWe,
  output logic          regRe
);
  logic weQ;
  logic reQ;

  always_comb begin
    stb.capture    = chainSel & captureDr;
    stb.shift      = chainSel & shiftDr;
    stb.update     = chainSel & updateDr;
    stb.loadShadow = reQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ <= 1'b0;
      reQ <= 1'b0;
    end else begin
      weQ <= stb.update & flagBit;
      reQ <= stb.update & ~flagBit;
    end
  end

  assign regWe = weQ;
  assign regRe = reQ;

  // R4 R5
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R5
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe);

  // R8
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chainSel || !updateDr) |=> !(regWe || regRe));
endmodule

// File: rtl/trace_chain_dp.sv
module trace_chain_dp
  import trace_chain_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobes_t     stb,
  input  logic              tdi,
  input  logic [DATA_W-1:0] regRdata,
  output logic              tdo,
  output logic              flagBit,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata
);
  localparam int CHAIN_W  = DATA_W + ADDR_W + 1;
  localparam int FLAG_POS = CHAIN_W - 1;

  logic [CHAIN_W-1:0] chainQ;
  logic [DATA_W-1:0]  shadowQ;
  logic [ADDR_W-1:0]  addrHold;
  logic [DATA_W-1:0]  dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '0;
    end else if (stb.capture) begin
      chainQ <= {1'b0, {ADDR_W{1'b0}}, shadowQ};
    end else if (stb.shift) begin
      chainQ <= {tdi, chainQ[CHAIN_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else if (stb.update) begin
      addrHold <= chainQ[DATA_W +: ADDR_W];
      dataHold <= chainQ[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else if (stb.loadShadow) begin
      shadowQ <= regRdata;
    end
  end

  assign tdo      = chainQ[0];
  assign flagBit  = chainQ[FLAG_POS];
  assign regAddr  = addrHold;
  assign regWdata = dataHold;

  // R3
  cap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (chainQ[CHAIN_W-1:DATA_W] == '0));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> (chainQ[CHAIN_W-2:0] == $past(chainQ[CHAIN_W-1:1])));

  // R8
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.capture || stb.shift) |=> $stable(chainQ));

  // R7
  shadow_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadShadow |=> $stable(shadowQ));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.update |=> ($stable(regAddr) && $stable(regWdata)));
endmodule

// File: rtl/trace_reg_chain.sv
module trace_reg_chain
  import trace_chain_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainSel,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);
  chainStrobes_t stb;
  logic          flagBit;

  trace_chain_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chainSel (chainSel),
    .captureDr(captureDr),
    .shiftDr  (shiftDr),
    .updateDr (updateDr),
    .flagBit  (flagBit),
    .stb      (stb),
    .regWe    (regWe),
    .regRe    (regRe)
  );

  trace_chain_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .tdi     (tdi),
    .regRdata(regRdata),
    .tdo     (tdo),
    .flagBit (flagBit),
    .regAddr (regAddr),
    .regWdata(regWdata)
  );
endmodule

// File: tb/test_trace_reg_chain.sv
module test_trace_reg_chain;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chainSel = 1'b0;
  logic        captureDr = 1'b0;
  logic        shiftDr = 1'b0;
  logic        updateDr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [6:0]  regAddr;
  logic [31:0] regWdata;
  logic        regWe;
  logic        regRe;
  logic [31:0] regRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] ID_WORD = 32'h4B1D_0001;

  always #5 clk = ~clk;

  trace_reg_chain i_trace_reg_chain (
    .clk(clk), .rstN(rstN), .chainSel(chainSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  function automatic logic [31:0] initWord(int a);
    return 32'hDEAD_0000 | 32'(a);
  endfunction

  function automatic logic [31:0] streamWord(int p);
    return 32'hC0DE_0000 + 32'(p * 7);
  endfunction

  // Register bank environment
  logic [31:0] envBank [128];
  int envPtr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < 128; a++) envBank[a] <= initWord(a);
      envPtr <= 0;
    end else begin
      if (regWe && regAddr != 7'd0 && regAddr != 7'd4) envBank[regAddr] <= regWdata;
      if (regRe && regAddr == 7'd4) envPtr <= envPtr + 1;
    end
  end

  always_comb begin
    if (regAddr == 7'd0)      regRdata = ID_WORD;
    else if (regAddr == 7'd4) regRdata = streamWord(envPtr);
    else                      regRdata = envBank[regAddr];
  end

  // Expected model
  logic [31:0] expBank [128];
  logic [31:0] expShadow;
  int expPtr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doScan(input logic [39:0] vec, output logic [39:0] cap,
                        output logic sawWe, output logic sawRe,
                        output logic [6:0] sawAddr, output logic [31:0] sawData,
                        output logic gone);
    @(negedge clk) captureDr = 1'b1;
    @(negedge clk) captureDr = 1'b0;
    for (int i = 0; i < 40; i++) begin
      cap[i] = tdo;
      tdi = vec[i];
      shiftDr = 1'b1;
      @(negedge clk);
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge clk) updateDr = 1'b0;
    sawWe = regWe; sawRe = regRe; sawAddr = regAddr; sawData = regWdata;
    @(negedge clk);
    gone = !regWe && !regRe;
  endtask

  task automatic runScan(input int addr, input logic [31:0] data, input bit isWr);
    logic [39:0] cap;
    logic w, r, g;
    logic [6:0] sa;
    logic [31:0] sd;
    logic [39:0] vec;
    vec = {isWr, 7'(addr), data};
    doScan(vec, cap, w, r, sa, sd, g);
    check(cap == {8'h00, expShadow}, "R3 R6 R7", "captured chain",
          64'(cap), 64'({8'h00, expShadow}));
    if (isWr) begin
      check(w == 1'b1 && r == 1'b0, "R4", "write strobe", {w, r}, 2'b10);
      check(sd == data, "R4", "write data", 64'(sd), 64'(data));
    end else begin
      check(r == 1'b1 && w == 1'b0, "R5", "read strobe", {w, r}, 2'b01);
    end
    check(sa == 7'(addr), "R4 R5", "address", 64'(sa), 64'(addr));
    check(g, "R4 R5", "single-cycle strobe", 64'(!g), 0);
    if (isWr) begin
      if (addr != 0 && addr != 4) expBank[addr] = data;
    end else if (addr == 0) begin
      expShadow = ID_WORD;
    end else if (addr == 4) begin
      expShadow = streamWord(expPtr);
      expPtr++;
    end else begin
      expShadow = expBank[addr];
    end
  endtask

  initial begin
    logic [39:0] vecV;
    logic [39:0] outV;
    bit quiet;
    int startPtr;
    for (int a = 0; a < 128; a++) expBank[a] = initWord(a);
    expShadow = '0;
    expPtr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tdo == 1'b0 && regWe == 1'b0 && regRe == 1'b0, "R1", "reset strobes",
          {tdo, regWe, regRe}, 0);
    check(regAddr == 7'd0 && regWdata == 32'd0, "R1", "reset address/data",
          {regAddr, regWdata}, 0);
    rstN = 1'b1;
    chainSel = 1'b1;
    @(negedge clk);

    // R1 R4: first scan captures zero, writes addr 9
    runScan(9, 32'h1234_5678, 1'b1);
    // R5 R6: read 9, then read 0 returns it
    runScan(9, 32'hFFFF_FFFF, 1'b0);
    runScan(0, 32'h0, 1'b0);
    // R7: read 9, write 10, read 0 -> shadow still holds addr 9 value
    runScan(9, 32'h0, 1'b0);
    runScan(10, 32'hAAAA_5555, 1'b1);
    runScan(0, 32'h0, 1'b0);
    runScan(0, 32'h0, 1'b0);

    // R6: sweep all addresses, writes then pipelined reads
    for (int a = 1; a < 128; a++)
      if (a != 4) runScan(a, 32'h1000_0000 ^ (32'(a) * 32'h0101_0101), 1'b1);
    for (int a = 1; a < 128; a++)
      if (a != 4) runScan(a, 32'h0, 1'b0);
    runScan(0, 32'h0, 1'b0);

    // R10: stream six trace words, finish with address 0
    startPtr = envPtr;
    for (int k = 0; k < 6; k++) runScan(4, 32'h0, 1'b0);
    runScan(0, 32'h0, 1'b0);
    runScan(0, 32'h0, 1'b0);
    check(envPtr - startPtr == 6, "R10", "trace words pulled",
          64'(envPtr - startPtr), 6);
    check(envPtr == expPtr, "R10", "stream pointer", 64'(envPtr), 64'(expPtr));

    // R8 R9 R2: load a known chain, then pulse strobes while unselected
    vecV = {1'b0, 7'd0, 32'h9C3A_61E5};
    runScan(0, 32'h9C3A_61E5, 1'b0);
    chainSel = 1'b0;
    quiet = 1;
    @(negedge clk) captureDr = 1'b1;
    @(negedge clk) captureDr = 1'b0;
    quiet &= !regWe && !regRe;
    for (int i = 0; i < 5; i++) begin
      tdi = 1'b1; shiftDr = 1'b1;
      @(negedge clk);
      quiet &= !regWe && !regRe;
    end
    shiftDr = 1'b0; updateDr = 1'b1;
    @(negedge clk) updateDr = 1'b0;
    quiet &= !regWe && !regRe;
    @(negedge clk);
    quiet &= !regWe && !regRe;
    check(quiet, "R8", "no strobe while unselected", 64'(!quiet), 0);
    chainSel = 1'b1;
    for (int i = 0; i < 40; i++) begin
      outV[i] = tdo;
      tdi = 1'b0; shiftDr = 1'b1;
      @(negedge clk);
    end
    shiftDr = 1'b0;
    check(outV == vecV, "R8 R2", "chain kept, LSB first", 64'(outV), 64'(vecV));
    check(regAddr == 7'd0 && regWdata == 32'h9C3A_61E5, "R9", "held address/data",
          {regAddr, regWdata}, {7'd0, 32'h9C3A_61E5});
    // the shadow holds the ID word from the last read
    runScan(0, 32'h0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule